// File: doc/BRIEF.md
# Half-Bridge Current-Sense Fault Monitor

This block sits between the sense-resistor comparators of a resonant half-bridge controller and its mode sequencer. It receives two comparator flags, already synchronized to the clock. One flag says the sensed current is above the high threshold. The other says it is below the low threshold. It also receives the present mode code from the sequencer and the low-side gate drive signal. It decides, on every switching cycle, whether the sensed current means the bridge must stop.

The high-threshold check is armed from the start of the ignition ramp onward. An event there in ignition means a lamp that will not strike or hard switching. In run it means over-current or hard switching. The low-threshold check is armed only in run. It is read only in the clock cycle where the low-side drive falls. A low-current reading at that moment means no load or operation below resonance.

When a fault is found, the block raises a request and a 2-bit cause code. Both stay fixed until the sequencer has entered its fault state and then left it. Storing the fault and resetting it remain the sequencer's job.

Top module: `csm_fault_monitor`

## Requirements
- R1: After reset, `fault_req` is 0 and `fault_cause` is 2'b00 (none).
- R2: `over_i` has no effect while the mode code is off (3'd0), preheat (3'd1), fault (3'd4) or any unused code (3'd5 to 3'd7).
- R3: With no request pending, `over_i` high for a single cycle in ignition (3'd2) or run (3'd3) sets `fault_req` to 1 and `fault_cause` to 2'b01 (over-current) after that clock edge.
- R4: `under_i` has no effect outside run, and no effect in run except in the cycle where the low-side drive falls. That cycle is the one where `lo_gate_i` is 0 and was 1 at the previous clock edge.
- R5: With no request pending, `under_i` high in run during a low-side falling cycle sets `fault_req` to 1 and `fault_cause` to 2'b10 (under-current) after that clock edge.
- R6: When both checks fire in the same cycle, the cause reported is 2'b01.
- R7: Once a request is pending, `fault_req` and `fault_cause` hold their values and ignore later events. They clear to 0 and 2'b00 one cycle after the first cycle in which the mode code is not fault while it was fault at the previous clock edge. The clear wins over a detection in that same cycle.
- R8: `fault_req` is 1 exactly when `fault_cause` is not 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 3 | Sequencer mode: 0 off, 1 preheat, 2 ignition, 3 run, 4 fault |
| over_i | input | 1 | Sensed current above high threshold (synchronized) |
| under_i | input | 1 | Sensed current below low threshold (synchronized) |
| lo_gate_i | input | 1 | Low-side gate drive, 1 = on |
| fault_req_o | output | 1 | Fault request to the sequencer |
| fault_cause_o | output | 2 | 00 none, 01 over-current, 10 under-current |

## Verification
The properties assume that both comparator flags and the gate signal are already synchronous to the clock and stable around each edge. They also assume the mode code changes only at clock edges. The bench drives every input on the falling clock edge, so these assumptions always hold. Its random phase draws unused mode codes and single-cycle flag pulses, and it toggles the gate freely. This covers falling edges in every mode, including falling edges that coincide with mode changes and with the exit from the fault state.

// File: rtl/csm_pkg.sv
package csm_pkg;

    localparam int MODE_W  = 3;
    localparam int CAUSE_W = 2;

    typedef enum logic [MODE_W-1:0] {
        MODE_OFF     = 3'd0,
        MODE_PREHEAT = 3'd1,
        MODE_IGNITE  = 3'd2,
        MODE_RUN     = 3'd3,
        MODE_FAULT   = 3'd4
    } mode_e;

    typedef enum logic [CAUSE_W-1:0] {
        CAUSE_NONE  = 2'b00,
        CAUSE_OVER  = 2'b01,
        CAUSE_UNDER = 2'b10
    } cause_e;

endpackage

// File: rtl/csm_gate_edge.sv
// Registered copy of the low-side drive; flags the cycle in which it falls.
module csm_gate_edge (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic lo_gate_i,
    output logic fall_o
);

    typedef struct packed {
        logic lo;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.lo = lo_gate_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign fall_o = st_q.lo & ~lo_gate_i;

endmodule

// File: rtl/csm_window.sv
// Mode-dependent arming of the two current checks.
module csm_window
    import csm_pkg::*;
(
    input  logic [MODE_W-1:0] mode_i,
    input  logic              over_i,
    input  logic              under_i,
    input  logic              fall_i,
    output logic              hit_over_o,
    output logic              hit_under_o
);

    logic over_armed, under_armed;

    always_comb begin
        over_armed  = 1'b0;
        under_armed = 1'b0;
        case (mode_i)
            MODE_IGNITE: over_armed = 1'b1;
            MODE_RUN: begin
                over_armed  = 1'b1;
                under_armed = 1'b1;
            end
            default: ;
        endcase
    end

    assign hit_over_o  = over_armed & over_i;
    assign hit_under_o = under_armed & fall_i & under_i;

endmodule

// File: rtl/csm_cause_hold.sv
// Holds the first fault cause until the sequencer leaves its fault state.
module csm_cause_hold
    import csm_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [MODE_W-1:0]  mode_i,
    input  logic               hit_over_i,
    input  logic               hit_under_i,
    output logic               req_o,
    output logic [CAUSE_W-1:0] cause_o
);

    typedef struct packed {
        logic               pend;
        logic [CAUSE_W-1:0] cause;
        logic [MODE_W-1:0]  mode;
    } hold_st_t;

    hold_st_t st_d, st_q;
    logic     leaving_fault;

    always_comb begin
        st_d          = st_q;
        st_d.mode     = mode_i;
        leaving_fault = (st_q.mode == MODE_FAULT) && (mode_i != MODE_FAULT);
        if (leaving_fault) begin
            st_d.pend  = 1'b0;
            st_d.cause = CAUSE_NONE;
        end else if (!st_q.pend) begin
            if (hit_over_i) begin
                st_d.pend  = 1'b1;
                st_d.cause = CAUSE_OVER;
            end else if (hit_under_i) begin
                st_d.pend  = 1'b1;
                st_d.cause = CAUSE_UNDER;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{pend: 1'b0, cause: CAUSE_NONE, mode: MODE_OFF};
        else         st_q <= st_d;
    end

    assign req_o   = st_q.pend;
    assign cause_o = st_q.cause;

endmodule

// File: rtl/csm_fault_monitor.sv
module csm_fault_monitor
    import csm_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [MODE_W-1:0]  mode_i,
    input  logic               over_i,
    input  logic               under_i,
    input  logic               lo_gate_i,
    output logic               fault_req_o,
    output logic [CAUSE_W-1:0] fault_cause_o
);

    logic lo_fall, hit_over, hit_under;

    csm_gate_edge u_edge (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .lo_gate_i (lo_gate_i),
        .fall_o    (lo_fall)
    );

    csm_window u_win (
        .mode_i      (mode_i),
        .over_i      (over_i),
        .under_i     (under_i),
        .fall_i      (lo_fall),
        .hit_over_o  (hit_over),
        .hit_under_o (hit_under)
    );

    csm_cause_hold u_hold (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .mode_i      (mode_i),
        .hit_over_i  (hit_over),
        .hit_under_i (hit_under),
        .req_o       (fault_req_o),
        .cause_o     (fault_cause_o)
    );

endmodule

// File: rtl/csm_fault_monitor_chk.sv
module csm_fault_monitor_chk
    import csm_pkg::*;
(
    input logic               clk_i,
    input logic               rst_ni,
    input logic [MODE_W-1:0]  mode_i,
    input logic               over_i,
    input logic               under_i,
    input logic               lo_gate_i,
    input logic               fault_req_o,
    input logic [CAUSE_W-1:0] fault_cause_o
);

    logic [MODE_W-1:0] c_mode_q;
    logic              c_lo_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            c_mode_q <= MODE_OFF;
            c_lo_q   <= 1'b0;
        end else begin
            c_mode_q <= mode_i;
            c_lo_q   <= lo_gate_i;
        end
    end

    logic c_exit, c_fall, c_over_armed;
    assign c_exit       = (c_mode_q == MODE_FAULT) && (mode_i != MODE_FAULT);
    assign c_fall       = c_lo_q && !lo_gate_i;
    assign c_over_armed = (mode_i == MODE_IGNITE) || (mode_i == MODE_RUN);

    p_req_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fault_req_o == (fault_cause_o != CAUSE_NONE));

    p_over_ignored_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!fault_req_o && !c_over_armed) |=> !fault_req_o);

    p_over_raises_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!fault_req_o && !c_exit && c_over_armed && over_i)
        |=> (fault_req_o && fault_cause_o == CAUSE_OVER));

    p_under_edge_only_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!fault_req_o && mode_i == MODE_RUN && !over_i && !c_fall) |=> !fault_req_o);

    p_under_raises_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!fault_req_o && !c_exit && mode_i == MODE_RUN && !over_i && under_i && c_fall)
        |=> (fault_cause_o == CAUSE_UNDER));

    p_both_over_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!fault_req_o && !c_exit && mode_i == MODE_RUN && over_i && under_i && c_fall)
        |=> (fault_cause_o == CAUSE_OVER));

    p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fault_req_o && !c_exit) |=> (fault_req_o && $stable(fault_cause_o)));

    p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        c_exit |=> (!fault_req_o && fault_cause_o == CAUSE_NONE));

endmodule

bind csm_fault_monitor csm_fault_monitor_chk u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .mode_i        (mode_i),
    .over_i        (over_i),
    .under_i       (under_i),
    .lo_gate_i     (lo_gate_i),
    .fault_req_o   (fault_req_o),
    .fault_cause_o (fault_cause_o)
);

// File: tb/sim_csm_fault_monitor.sv
`timescale 1ns/1ps
module sim_csm_fault_monitor;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] mode = 3'd0;
    logic       over = 1'b0;
    logic       under = 1'b0;
    logic       lo = 1'b0;
    logic       req;
    logic [1:0] cause;

    int checks = 0;
    int fails  = 0;

    // reference state
    logic       m_pend = 1'b0;
    logic [1:0] m_cause = 2'b00;
    logic [2:0] m_mode = 3'd0;
    logic       m_lo = 1'b0;

    always #2.5 clk = ~clk;

    csm_fault_monitor u0 (
        .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .over_i(over),
        .under_i(under), .lo_gate_i(lo), .fault_req_o(req), .fault_cause_o(cause)
    );

    function automatic logic armed_over(input logic [2:0] md);
        return (md == 3'd2) || (md == 3'd3);
    endfunction

    function automatic logic [1:0] next_cause(input logic [2:0] md, input logic ov,
                                             input logic un, input logic fall);
        if (ov && armed_over(md))             return 2'b01;
        if (un && md == 3'd3 && fall)         return 2'b10;
        return 2'b00;
    endfunction

    task automatic model_edge();
        logic [1:0] nc;
        nc = next_cause(mode, over, under, m_lo && !lo);
        if (m_mode == 3'd4 && mode != 3'd4) begin
            m_pend = 1'b0; m_cause = 2'b00;
        end else if (!m_pend && nc != 2'b00) begin
            m_pend = 1'b1; m_cause = nc;
        end
        m_mode = mode;
        m_lo   = lo;
    endtask

    task automatic chk(input string tag, input logic er, input logic [1:0] ec);
        checks++;
        if (req !== er || cause !== ec) begin
            fails++;
            $display("FAIL %s: req=%b cause=%b expected req=%b cause=%b", tag, req, cause, er, ec);
        end
    endtask

    task automatic step(input logic [2:0] md, input logic ov, input logic un,
                        input logic lg, input string tag);
        @(negedge clk);
        mode = md; over = ov; under = un; lo = lg;
        @(posedge clk);
        model_edge();
        #1;
        chk(tag, m_pend, m_cause);
    endtask

    // pass through the fault state to clear any pending request
    task automatic clear_seq(input string tag);
        step(3'd4, 1'b0, 1'b0, 1'b0, tag);
        step(3'd0, 1'b0, 1'b0, 1'b0, tag);
        step(3'd0, 1'b0, 1'b0, 1'b0, tag);
    endtask

    initial begin
        process::self().srandom(32'd1357);
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset", 1'b0, 2'b00);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 after release", 1'b0, 2'b00);

        // R2: over ignored in off, preheat, fault, unused codes
        step(3'd0, 1'b1, 1'b0, 1'b0, "R2 off");
        chk("R2 off no req", 1'b0, 2'b00);
        step(3'd1, 1'b1, 1'b0, 1'b0, "R2 preheat");
        chk("R2 preheat no req", 1'b0, 2'b00);
        step(3'd4, 1'b1, 1'b0, 1'b0, "R2 fault mode");
        step(3'd6, 1'b1, 1'b0, 1'b0, "R2 unused code");
        chk("R2 unused no req", 1'b0, 2'b00);
        step(3'd0, 1'b0, 1'b0, 1'b0, "R2 settle");

        // R3: single-cycle over pulse in ignition
        step(3'd2, 1'b1, 1'b0, 1'b0, "R3 ignite over");
        chk("R3 ignite cause 01", 1'b1, 2'b01);
        // R7: held, later under event ignored
        step(3'd3, 1'b0, 1'b0, 1'b1, "R7 hold a");
        step(3'd3, 1'b0, 1'b1, 1'b0, "R7 hold under ignored");
        chk("R7 still 01", 1'b1, 2'b01);
        step(3'd4, 1'b0, 1'b0, 1'b0, "R7 in fault");
        chk("R7 held in fault", 1'b1, 2'b01);
        // clear wins over a detection in the exit cycle
        step(3'd2, 1'b1, 1'b0, 1'b0, "R7 exit with over");
        chk("R7 cleared", 1'b0, 2'b00);
        step(3'd0, 1'b0, 1'b0, 1'b0, "R7 settle");

        // R3: over in run
        step(3'd3, 1'b1, 1'b0, 1'b0, "R3 run over");
        chk("R3 run cause 01", 1'b1, 2'b01);
        clear_seq("R7 clear");

        // R4: under in ignition at falling edge ignored
        step(3'd2, 1'b0, 1'b0, 1'b1, "R4 ign lo high");
        step(3'd2, 1'b0, 1'b1, 1'b0, "R4 ign fall under");
        chk("R4 ignition ignored", 1'b0, 2'b00);
        // R4: under in run without edge ignored
        step(3'd3, 1'b0, 1'b1, 1'b0, "R4 run lo low");
        step(3'd3, 1'b0, 1'b1, 1'b1, "R4 run rise");
        step(3'd3, 1'b0, 1'b1, 1'b1, "R4 run lo high");
        chk("R4 no edge ignored", 1'b0, 2'b00);
        // R5: falling edge with under
        step(3'd3, 1'b0, 1'b1, 1'b0, "R5 run fall under");
        chk("R5 cause 10", 1'b1, 2'b10);
        clear_seq("R7 clear 2");

        // R6: both at once
        step(3'd3, 1'b0, 1'b0, 1'b1, "R6 lo high");
        step(3'd3, 1'b1, 1'b1, 1'b0, "R6 both");
        chk("R6 over wins", 1'b1, 2'b01);
        clear_seq("R7 clear 3");

        // random phase
        for (int i = 0; i < 4000; i++) begin
            logic [2:0] md;
            int r;
            r = $urandom_range(0, 19);
            if (r < 3)       md = 3'd0;
            else if (r < 5)  md = 3'd1;
            else if (r < 9)  md = 3'd2;
            else if (r < 15) md = 3'd3;
            else if (r < 19) md = 3'd4;
            else             md = 3'($urandom_range(5, 7));
            step(md, ($urandom_range(0, 9) == 0), ($urandom_range(0, 3) == 0),
                 1'($urandom_range(0, 1)), "R8 random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule